// File: doc/BRIEF.md
# Windowed Scalar Multiplication Sequencer

This block sequences an elliptic-curve scalar multiplication of the form Q = k·P1 + n·P2 without doing any point arithmetic itself. The scalar is 255 bits wide. Its top bit seeds the accumulator. The other 254 bits are consumed two at a time, from the most significant pair down, against precomputed multiples 2·P1 and 3·P1. A one-bit flag can add a second point P2 after the loop, which is the form used when a signature is verified.

Points live in a register file inside an external point unit. The sequencer names operand and destination slots in each command. The fixed slot map is: 0 = P1, 1 = P2, 2 = 2·P1, 3 = 3·P1, 4 and 5 = the two accumulator slots. The caller loads P1 and P2 into the point unit, pulses `start_i` with the scalar and the flag, and waits for `done_o`. When `done_o` is high, `result_slot_o` names the slot that holds Q. Each command goes out on a valid/ready channel. The unit then signals completion with a one-cycle `cmd_done_i`, and only after that is the next command issued.

Top module: `scalar_mult_seq`

## Requirements
- R1: After start, the first two commands build the multiples in order: DBL (op 0) from slot 0 into slot 2, then ADD (op 1) with src_a = 2 and src_b = 0 into slot 3.
- R2: The third command seeds the accumulator. It is MOV (op 2, src_a = src_b = 0) when scalar bit 254 is 1, and LDI (op 3, load identity, sources 0) when that bit is 0. Its destination is slot 5.
- R3: For each 2-bit window, from bits [253:252] down to [1:0], the block issues two DBL commands of the accumulator (src_a = src_b). If the window digit is nonzero, an ADD follows with src_a = accumulator and src_b = slot 0, 2 or 3 for digit 1, 2 or 3. A zero digit issues no ADD.
- R4: When add_p2_i was 1 at start, one final ADD with src_a = accumulator and src_b = slot 1 follows the last window. When it was 0, no such command is issued.
- R5: The slot named by result_slot_o at done holds k·P1 + n·P2 in the point group.
- R6: cmd_valid_o stays high with all command fields unchanged until cmd_ready_i is seen. At most one command is outstanding. The next command is raised only after cmd_done_i for the previous one.
- R7: Every command that writes the accumulator reads the current accumulator slot and writes the other one of slots 4 and 5. Slot 4 is current at start. result_slot_o names the slot last written.
- R8: done_o is high for exactly one cycle, in the cycle after the cmd_done_i of the final command.
- R9: A start_i pulse while the block is busy has no effect on the running command sequence or its result.
- R10: After reset, busy_o, done_o and cmd_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication (taken only when idle) |
| scalar_i | input | 255 | Scalar k, sampled at an accepted start |
| add_p2_i | input | 1 | Add P2 after the loop, sampled at an accepted start |
| cmd_valid_o | output | 1 | Command is presented |
| cmd_ready_i | input | 1 | Point unit accepts the command |
| cmd_op_o | output | 2 | 0 DBL, 1 ADD, 2 MOV, 3 LDI |
| cmd_dst_o | output | 3 | Destination slot |
| cmd_src_a_o | output | 3 | First source slot |
| cmd_src_b_o | output | 3 | Second source slot |
| cmd_done_i | input | 1 | One-cycle completion of the accepted command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| result_slot_o | output | 3 | Slot holding the result |

## Verification
The first command appears one cycle after an accepted start. Every later command appears one cycle after the cmd_done_i of the one before it. done_o rises one cycle after the final cmd_done_i. The bench drives and samples only on the falling edge, so each of these registered responses is observed at the first falling edge after the rising edge that produces it. The bench's point-unit model records the cycle of every completion and checks the done pulse against the cycle number it recorded. Every accepted command is compared with a sequence that the bench builds from the scalar and the flag, and the final value is checked against k·P1 + n·P2 computed with integers modulo a prime.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int SLOT_W = 3;

  typedef enum logic [1:0] {
    OP_DBL = 2'd0,
    OP_ADD = 2'd1,
    OP_MOV = 2'd2,
    OP_LDI = 2'd3
  } pt_op_e;

  localparam logic [SLOT_W-1:0] SLOT_P1   = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_P2   = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_P1X2 = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_P1X3 = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_QA   = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_QB   = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_DBL,
    ST_PRE_ADD,
    ST_INIT,
    ST_WIN_DBL0,
    ST_WIN_DBL1,
    ST_WIN_ADD,
    ST_FIN_ADD,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    pt_op_e            op;
    logic [SLOT_W-1:0] dst;
    logic [SLOT_W-1:0] src_a;
    logic [SLOT_W-1:0] src_b;
  } pt_cmd_t;
endpackage

// File: rtl/smc_digit_src.sv
module smc_digit_src #(
  parameter int SCALAR_W = 255
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SCALAR_W-1:0] scalar_i,
  input  logic                shift_i,
  output logic                top_bit_o,
  output logic [1:0]          digit_o,
  output logic                last_win_o
);
  localparam int BODY_W = SCALAR_W - 1;
  localparam int NWIN   = BODY_W / 2;
  localparam int CNT_W  = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic [BODY_W-1:0] body_q;
  logic              top_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      top_q <= scalar_i[SCALAR_W-1];
      cnt_q <= CNT_W'(NWIN - 1);
    end else if (shift_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // window register: current digit always sits in the top two bits
  generate
    if (BODY_W > 2) begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      body_q <= '0;
        else if (load_i)  body_q <= scalar_i[BODY_W-1:0];
        else if (shift_i) body_q <= {body_q[BODY_W-3:0], 2'b00};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     body_q <= '0;
        else if (load_i) body_q <= scalar_i[BODY_W-1:0];
      end
    end
  endgenerate

  assign top_bit_o  = top_q;
  assign digit_o    = body_q[BODY_W-1 -: 2];
  assign last_win_o = (cnt_q == '0);
endmodule

// File: rtl/smc_cmd_port.sv
module smc_cmd_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic cmd_ready_i,
  input  logic cmd_done_i,
  output logic cmd_valid_o,
  output logic cmp_o
);
  logic pending_q;

  assign cmd_valid_o = req_i && !pending_q;
  assign cmp_o       = pending_q && cmd_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pending_q <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i) pending_q <= 1'b1;
    else if (cmp_o)                     pending_q <= 1'b0;
  end
endmodule

// File: rtl/smc_acc_slot.sv
module smc_acc_slot
  import smc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              flip_i,
  output logic [SLOT_W-1:0] cur_o,
  output logic [SLOT_W-1:0] nxt_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= 1'b0;
    else if (clear_i) sel_q <= 1'b0;
    else if (flip_i)  sel_q <= ~sel_q;
  end

  assign cur_o = sel_q ? SLOT_QB : SLOT_QA;
  assign nxt_o = sel_q ? SLOT_QA : SLOT_QB;
endmodule

// File: rtl/smc_cmd_mux.sv
module smc_cmd_mux
  import smc_pkg::*;
(
  input  seq_state_e        state_i,
  input  logic              top_bit_i,
  input  logic [1:0]        digit_i,
  input  logic [SLOT_W-1:0] cur_i,
  input  logic [SLOT_W-1:0] nxt_i,
  output pt_cmd_t           cmd_o
);
  logic [SLOT_W-1:0] mult_slot;

  // digit 1 -> P1, digits 2/3 map onto their own slot numbers
  assign mult_slot = (digit_i == 2'd1) ? SLOT_P1 : SLOT_W'(digit_i);

  always_comb begin
    cmd_o = '{op: OP_DBL, dst: '0, src_a: '0, src_b: '0};
    unique case (state_i)
      ST_PRE_DBL:  cmd_o = '{op: OP_DBL, dst: SLOT_P1X2, src_a: SLOT_P1,   src_b: SLOT_P1};
      ST_PRE_ADD:  cmd_o = '{op: OP_ADD, dst: SLOT_P1X3, src_a: SLOT_P1X2, src_b: SLOT_P1};
      ST_INIT: begin
        if (top_bit_i) cmd_o = '{op: OP_MOV, dst: nxt_i, src_a: SLOT_P1, src_b: SLOT_P1};
        else           cmd_o = '{op: OP_LDI, dst: nxt_i, src_a: '0,      src_b: '0};
      end
      ST_WIN_DBL0,
      ST_WIN_DBL1: cmd_o = '{op: OP_DBL, dst: nxt_i, src_a: cur_i, src_b: cur_i};
      ST_WIN_ADD:  cmd_o = '{op: OP_ADD, dst: nxt_i, src_a: cur_i, src_b: mult_slot};
      ST_FIN_ADD:  cmd_o = '{op: OP_ADD, dst: nxt_i, src_a: cur_i, src_b: SLOT_P2};
      default:     cmd_o = '{op: OP_DBL, dst: '0, src_a: '0, src_b: '0};
    endcase
  end
endmodule

// File: rtl/scalar_mult_seq.sv
module scalar_mult_seq
  import smc_pkg::*;
#(
  parameter int SCALAR_W = 255
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SCALAR_W-1:0] scalar_i,
  input  logic                add_p2_i,
  output logic                cmd_valid_o,
  input  logic                cmd_ready_i,
  output logic [1:0]          cmd_op_o,
  output logic [SLOT_W-1:0]   cmd_dst_o,
  output logic [SLOT_W-1:0]   cmd_src_a_o,
  output logic [SLOT_W-1:0]   cmd_src_b_o,
  input  logic                cmd_done_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [SLOT_W-1:0]   result_slot_o
);
  seq_state_e        state_q, state_d;
  logic              add_p2_q;
  logic              load, shift, flip, clear, req, cmp;
  logic              top_bit, last_win;
  logic [1:0]        digit;
  logic [SLOT_W-1:0] cur_slot, nxt_slot;
  pt_cmd_t           cmd;

  smc_digit_src #(.SCALAR_W(SCALAR_W)) u_digits (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .scalar_i   (scalar_i),
    .shift_i    (shift),
    .top_bit_o  (top_bit),
    .digit_o    (digit),
    .last_win_o (last_win)
  );

  smc_acc_slot u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .flip_i  (flip),
    .cur_o   (cur_slot),
    .nxt_o   (nxt_slot)
  );

  smc_cmd_mux u_mux (
    .state_i   (state_q),
    .top_bit_i (top_bit),
    .digit_i   (digit),
    .cur_i     (cur_slot),
    .nxt_i     (nxt_slot),
    .cmd_o     (cmd)
  );

  smc_cmd_port u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req),
    .cmd_ready_i (cmd_ready_i),
    .cmd_done_i  (cmd_done_i),
    .cmd_valid_o (cmd_valid_o),
    .cmp_o       (cmp)
  );

  assign req = (state_q != ST_IDLE) && (state_q != ST_DONE);

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    shift   = 1'b0;
    flip    = 1'b0;
    clear   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load    = 1'b1;
          clear   = 1'b1;
          state_d = ST_PRE_DBL;
        end
      end
      ST_PRE_DBL: if (cmp) state_d = ST_PRE_ADD;
      ST_PRE_ADD: if (cmp) state_d = ST_INIT;
      ST_INIT: begin
        if (cmp) begin
          flip    = 1'b1;
          state_d = ST_WIN_DBL0;
        end
      end
      ST_WIN_DBL0: begin
        if (cmp) begin
          flip    = 1'b1;
          state_d = ST_WIN_DBL1;
        end
      end
      ST_WIN_DBL1, ST_WIN_ADD: begin
        if (cmp) begin
          flip = 1'b1;
          if (state_q == ST_WIN_DBL1 && digit != 2'd0) begin
            state_d = ST_WIN_ADD;
          end else if (last_win) begin
            state_d = add_p2_q ? ST_FIN_ADD : ST_DONE;
          end else begin
            shift   = 1'b1;
            state_d = ST_WIN_DBL0;
          end
        end
      end
      ST_FIN_ADD: begin
        if (cmp) begin
          flip    = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      add_p2_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load) add_p2_q <= add_p2_i;
    end
  end

  assign cmd_op_o      = cmd.op;
  assign cmd_dst_o     = cmd.dst;
  assign cmd_src_a_o   = cmd.src_a;
  assign cmd_src_b_o   = cmd.src_b;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign result_slot_o = cur_slot;
endmodule

// File: rtl/smc_chk.sv
module smc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_o,
  input logic       cmd_ready_i,
  input logic [1:0] cmd_op_o,
  input logic [2:0] cmd_dst_o,
  input logic [2:0] cmd_src_a_o,
  input logic [2:0] cmd_src_b_o,
  input logic       cmd_done_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [2:0] result_slot_o
);
  // R6
  hold_until_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_dst_o)
      && $stable(cmd_src_a_o) && $stable(cmd_src_b_o));

  // R6
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i |=> !cmd_valid_o);

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_after_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(cmd_done_i));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o && !done_o);

  // R7
  pingpong_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_dst_o[2] |-> cmd_src_a_o != cmd_dst_o && cmd_src_b_o != cmd_dst_o);

  // R7
  result_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_slot_o == 3'd4 || result_slot_o == 3'd5));

  // R3
  dbl_same_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 2'd0 |-> cmd_src_a_o == cmd_src_b_o);
endmodule

bind scalar_mult_seq smc_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_o   (cmd_valid_o),
  .cmd_ready_i   (cmd_ready_i),
  .cmd_op_o      (cmd_op_o),
  .cmd_dst_o     (cmd_dst_o),
  .cmd_src_a_o   (cmd_src_a_o),
  .cmd_src_b_o   (cmd_src_b_o),
  .cmd_done_i    (cmd_done_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .result_slot_o (result_slot_o)
);

// File: tb/tb_scalar_mult_seq.sv
module tb_scalar_mult_seq;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 255;
  localparam longint MODP = 65521;

  typedef struct packed {
    logic [KW-1:0] k;
    logic          n;
    logic [3:0]    lat;
    logic [3:0]    stall;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{{KW{1'b1}},              1'b1, 4'd0, 4'd0},
    '{{85{3'b101}},            1'b0, 4'd2, 4'd1},
    '{{51{5'b10011}},          1'b1, 4'd1, 4'd3},
    '{{{(KW-1){1'b0}}, 1'b1},  1'b0, 4'd0, 4'd2},
    '{{1'b1, {(KW-1){1'b0}}},  1'b0, 4'd3, 4'd0},
    '{{KW{1'b0}},              1'b1, 4'd1, 4'd0},
    '{{1'b0, {127{2'b10}}},    1'b1, 4'd2, 4'd2}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [KW-1:0] scalar_i = '0;
  logic          add_p2_i = 1'b0;
  logic          cmd_valid_o, cmd_ready_i, cmd_done_i;
  logic [1:0]    cmd_op_o;
  logic [2:0]    cmd_dst_o, cmd_src_a_o, cmd_src_b_o, result_slot_o;
  logic          busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scalar_mult_seq dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .scalar_i (scalar_i),
    .add_p2_i (add_p2_i), .cmd_valid_o (cmd_valid_o), .cmd_ready_i (cmd_ready_i),
    .cmd_op_o (cmd_op_o), .cmd_dst_o (cmd_dst_o), .cmd_src_a_o (cmd_src_a_o),
    .cmd_src_b_o (cmd_src_b_o), .cmd_done_i (cmd_done_i), .busy_o (busy_o),
    .done_o (done_o), .result_slot_o (result_slot_o)
  );

  // expected command stream
  int exp_op [512];
  int exp_a  [512];
  int exp_b  [512];
  int exp_d  [512];
  int exp_len, exp_slot;
  longint exp_val;

  // point-unit model state
  longint regs [8];
  int  cyc = 0, done_cnt = 0, done_cyc = 0, cmp_cyc = 0;
  int  n_cmd = 0, pre_err = 0, init_err = 0, seq_err = 0, proto_err = 0;
  int  cur_lat = 0, cur_stall = 0, stall_cnt = 0, lat_cnt = 0;
  bit  unit_busy = 0, prev_wait = 0;
  logic [10:0] prev_f;
  int  u_op, u_a, u_b, u_d;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int op, input int a, input int b, input int d);
    exp_op[exp_len] = op; exp_a[exp_len] = a; exp_b[exp_len] = b; exp_d[exp_len] = d;
    exp_len++;
  endtask

  task automatic build_expected(input logic [KW-1:0] k, input logic n, input longint p1, input longint p2);
    int q;
    longint km;
    exp_len = 0;
    push(0, 0, 0, 2);
    push(1, 2, 0, 3);
    q = 4;
    if (k[KW-1]) push(2, 0, 0, 9 - q); else push(3, 0, 0, 9 - q);
    q = 9 - q;
    for (int i = (KW-1)/2 - 1; i >= 0; i--) begin
      int dg;
      dg = int'(k[2*i +: 2]);
      push(0, q, q, 9 - q); q = 9 - q;
      push(0, q, q, 9 - q); q = 9 - q;
      if (dg != 0) begin
        push(1, q, (dg == 1) ? 0 : dg, 9 - q);
        q = 9 - q;
      end
    end
    if (n) begin
      push(1, q, 1, 9 - q);
      q = 9 - q;
    end
    exp_slot = q;
    km = 0;
    for (int b = KW-1; b >= 0; b--) km = (km * 2 + longint'(k[b])) % MODP;
    exp_val = (km * p1 + (n ? p2 : 0)) % MODP;
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      cmd_ready_i = 1'b0;
      cmd_done_i  = 1'b0;
      unit_busy   = 0;
      prev_wait   = 0;
    end else begin
      cyc++;
      if (done_o) begin done_cnt++; done_cyc = cyc; end
      cmd_done_i  = 1'b0;
      cmd_ready_i = 1'b0;
      if (prev_wait && (!cmd_valid_o ||
          {cmd_op_o, cmd_dst_o, cmd_src_a_o, cmd_src_b_o} != prev_f)) proto_err++;
      prev_wait = 0;
      if (unit_busy) begin
        if (cmd_valid_o) proto_err++;
        if (lat_cnt == 0) begin
          case (u_op)
            0: regs[u_d] = (2 * regs[u_a]) % MODP;
            1: regs[u_d] = (regs[u_a] + regs[u_b]) % MODP;
            2: regs[u_d] = regs[u_a];
            default: regs[u_d] = 0;
          endcase
          cmd_done_i = 1'b1;
          cmp_cyc    = cyc;
          unit_busy  = 0;
          stall_cnt  = cur_stall;
        end else lat_cnt--;
      end else if (cmd_valid_o) begin
        if (stall_cnt == 0) begin
          cmd_ready_i = 1'b1;
          u_op = int'(cmd_op_o); u_a = int'(cmd_src_a_o);
          u_b = int'(cmd_src_b_o); u_d = int'(cmd_dst_o);
          if (n_cmd >= exp_len || u_op != exp_op[n_cmd] || u_a != exp_a[n_cmd] ||
              u_b != exp_b[n_cmd] || u_d != exp_d[n_cmd]) begin
            if (n_cmd < 2) pre_err++;
            else if (n_cmd == 2) init_err++;
            else seq_err++;
          end
          n_cmd++;
          unit_busy = 1;
          lat_cnt   = cur_lat;
        end else begin
          stall_cnt--;
          prev_wait = 1;
          prev_f    = {cmd_op_o, cmd_dst_o, cmd_src_a_o, cmd_src_b_o};
        end
      end
    end
  end

  task automatic run_one(input logic [KW-1:0] k, input logic n, input int lat, input int stall,
                         input longint p1, input longint p2, input bit inject);
    int d0;
    bit seen;
    build_expected(k, n, p1, p2);
    for (int s = 0; s < 8; s++) regs[s] = 999;
    regs[0] = p1; regs[1] = p2;
    n_cmd = 0; pre_err = 0; init_err = 0; seq_err = 0; proto_err = 0;
    cur_lat = lat; cur_stall = stall; stall_cnt = stall;
    d0 = done_cnt;
    @(negedge clk);
    scalar_i = k; add_p2_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      repeat (20) @(negedge clk);
      scalar_i = ~k; add_p2_i = ~n; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    seen = 0;
    for (int w = 0; w < 30000 && !seen; w++) begin
      @(negedge clk);
      if (done_cnt != d0) seen = 1;
    end
    chk(seen, "R8 done never seen", 0, 1);
    chk(result_slot_o == 3'(exp_slot), "R7 result slot", longint'(result_slot_o), exp_slot);
    chk(regs[result_slot_o] == exp_val, "R5 result value", regs[result_slot_o], exp_val);
    chk(done_cyc == cmp_cyc + 1, "R8 done one cycle after last completion", done_cyc, cmp_cyc + 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1, inject ? "R9 single done despite busy start" : "R8 done pulse width",
        done_cnt - d0, 1);
    chk(!busy_o && !done_o, "R8 idle after done", {busy_o, done_o}, 0);
    chk(pre_err == 0, "R1 precompute commands", pre_err, 0);
    chk(init_err == 0, "R2 accumulator seed command", init_err, 0);
    chk(seq_err == 0, "R3 window command sequence", seq_err, 0);
    chk(n_cmd == exp_len, "R4 command count (final P2 add)", n_cmd, exp_len);
    chk(proto_err == 0, "R6 handshake stability", proto_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_len = 0;
    repeat (3) @(negedge clk);
    // R10 during reset
    chk(!busy_o && !done_o && !cmd_valid_o, "R10 outputs in reset",
        {busy_o, done_o, cmd_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R10 after release, no start
    chk(!busy_o && !done_o && !cmd_valid_o, "R10 idle after reset",
        {busy_o, done_o, cmd_valid_o}, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_one(VECS[v].k, VECS[v].n, int'(VECS[v].lat), int'(VECS[v].stall),
              longint'(1234 + 17 * v), longint'(777 + 5 * v), 1'b0);
    end

    // R9: start pulse with a different scalar while busy must be ignored
    run_one({51{5'b01101}}, 1'b1, 2, 1, 4321, 99, 1'b1);
    // R2 and R4: zero scalar without P2 gives identity, seeded by LDI
    run_one({KW{1'b0}}, 1'b0, 0, 0, 55, 66, 1'b0);
    // R3: only the lowest window nonzero with digit 3
    run_one({{(KW-2){1'b0}}, 2'b11}, 1'b0, 1, 1, 321, 5, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule